// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps the time of day and a calendar in seven packed-BCD registers: seconds, minutes, hours, date, month, day of week and a two-digit year. A clock-enable input that pulses at 32.768 kHz is divided down to a one-second tick. On each tick the count ripples from seconds through to the year in a single cycle. The date rolls over at the real end of each month, and February gets a twenty-ninth day in leap years.

The hours register runs either in 24-hour form or in 12-hour form with a PM flag. Bit 7 of the seconds register is a halt flag that freezes all counting. A host loads or reads any register through a small parallel port made of an address, a write strobe, write data and combinational read data. The whole register set is also presented at once on a 56-bit snapshot bus.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset the registers hold seconds 00, minutes 00, hours 00 (24-hour form, halt clear), date 01, month 01, day of week 01 and year 00.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. A write stores the full byte. `reg_rdata` returns the byte at `reg_addr`. Address 7 reads 0 and writes to it change nothing. The snapshot carries register k at bits [8k+7:8k].
- R3: A tick occurs on every `DIV_RATIO`-th enabled time-base cycle while the clock is not halted. Cycles with `tbase_en` low do not advance the divider. A write to the seconds register clears the divider.
- R4: While seconds bit 7 is 1, no register changes except through host writes. Writing that bit to 0 resumes counting.
- R5: Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 and carries into the next field.
- R6: In 24-hour form (hours bit 7 = 0), hours count 00 to 23 in bits [5:0]. The step from 23 to 00 advances the date and the day of week.
- R7: In 12-hour form (hours bit 7 = 1), bits [4:0] hold 01 to 12 and bit 5 is PM (1 = PM). 11 steps to 12 and toggles PM, and 12 steps to 01. The step from 11 PM to 12 AM advances the date.
- R8: Months 04, 06, 09 and 11 end after day 30, and the other months except February end after day 31. The day after the last day is 01 of the next month.
- R9: February ends after day 29 when the BCD year is divisible by four (00 included), and after day 28 otherwise.
- R10: The day of week counts 1 to 7 and wraps from 7 to 1 at each date change.
- R11: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R12: In a cycle with a host write, no register counts. A tick that falls in that cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_en | input | 1 | 32.768 kHz time-base enable, one clk cycle wide |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| snap_out | output | 56 | All seven registers, seconds in the low byte |

## Verification
The bench goes after the carry chain's edges. It runs 23:59:59 into a 30-day month end, where a design that ignored month length would show day 31. It crosses February in the years 23, 24 and 00, where a wrong leap test gives a false or missing 29th. It runs December 31 of year 99, where a missing wrap leaves BCD garbage such as month 13 or year 9A. In 12-hour form it steps through 11 to 12 and 12 to 01, and through 11 PM to midnight. A design that toggled PM at the wrong step, showed hour 00, or failed to roll the date there would show a wrong hours byte or date. It also halts the clock, writes during a tick cycle and gates the enable, where a design that counted anyway would drift from the reference model on that same clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_COUNT = 7;
    localparam int BYTE_W    = 8;
    localparam int SNAP_W    = REG_COUNT * BYTE_W;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DATE  = 3'd3,
        A_MONTH = 3'd4,
        A_DOW   = 3'd5,
        A_YEAR  = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    // Seconds occupy the low byte of the packed value.
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] dow;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_regs_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Tens*10+ones is divisible by 4 exactly when tens*2+ones is.
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int DIV_RATIO = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tbase_en,
    input  logic halt,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step = tbase_en && !halt;
    assign tick = step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + 1'b1;
    end

    // R3: two ticks are never adjacent when the ratio is above one
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && DIV_RATIO > 1) |=> !tick);

endmodule

// File: rtl/rtc_next.sv
module rtc_next
    import rtc_pkg::*;
(
    input  rtc_regs_t cur,
    output rtc_regs_t nxt
);
    logic       sec_wrap, min_carry, day_carry, mon_carry, yr_carry;
    logic [7:0] s_inc, m_inc, h12_inc, h24_inc, d_inc, mo_inc, y_inc, last_day;
    logic       mode12, pm;

    assign mode12   = cur.hour[7];
    assign pm       = cur.hour[5];
    assign s_inc    = bcd_inc({1'b0, cur.sec[6:0]});
    assign m_inc    = bcd_inc(cur.min);
    assign h12_inc  = bcd_inc({3'b000, cur.hour[4:0]});
    assign h24_inc  = bcd_inc({2'b00, cur.hour[5:0]});
    assign d_inc    = bcd_inc(cur.date);
    assign mo_inc   = bcd_inc(cur.month);
    assign y_inc    = bcd_inc(cur.year);
    assign last_day = month_last_day(cur.month, cur.year);

    always_comb begin
        nxt       = cur;
        sec_wrap  = (cur.sec[6:0] == 7'h59);
        min_carry = sec_wrap && (cur.min == 8'h59);
        day_carry = 1'b0;
        mon_carry = 1'b0;
        yr_carry  = 1'b0;

        nxt.sec = sec_wrap ? {cur.sec[7], 7'h00} : (s_inc | {cur.sec[7], 7'h00});
        if (sec_wrap) nxt.min = (cur.min == 8'h59) ? 8'h00 : m_inc;

        if (min_carry) begin
            if (mode12) begin
                if (cur.hour[4:0] == 5'h11) begin
                    nxt.hour  = {1'b1, 1'b0, ~pm, 5'h12};
                    day_carry = pm;
                end else if (cur.hour[4:0] == 5'h12) begin
                    nxt.hour = {1'b1, 1'b0, pm, 5'h01};
                end else begin
                    nxt.hour = {1'b1, 1'b0, pm, 5'h00} | h12_inc;
                end
            end else begin
                day_carry = (cur.hour[5:0] == 6'h23);
                nxt.hour  = day_carry ? 8'h00 : h24_inc;
            end
        end

        if (day_carry) begin
            nxt.dow   = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'd1;
            mon_carry = (cur.date == last_day);
            nxt.date  = mon_carry ? 8'h01 : d_inc;
        end
        if (mon_carry) begin
            yr_carry  = (cur.month == 8'h12);
            nxt.month = yr_carry ? 8'h01 : mo_inc;
        end
        if (yr_carry) nxt.year = (cur.year == 8'h99) ? 8'h00 : y_inc;
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_RATIO = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tbase_en,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [55:0] snap_out
);
    localparam rtc_regs_t RESET_VAL = '{year: 8'h00, dow: 8'h01, month: 8'h01,
                                        date: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

    rtc_regs_t q, nxt;
    logic      tick, sec_write;
    reg_addr_e addr;

    assign addr      = reg_addr_e'(reg_addr);
    assign sec_write = reg_we && (addr == A_SEC);

    rtc_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk(clk), .rst(rst), .tbase_en(tbase_en),
        .halt(q.sec[7]), .clear(sec_write), .tick(tick)
    );

    rtc_next u_next (.cur(q), .nxt(nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (reg_we) begin
            case (addr)
                A_SEC:   q.sec   <= reg_wdata;
                A_MIN:   q.min   <= reg_wdata;
                A_HOUR:  q.hour  <= reg_wdata;
                A_DATE:  q.date  <= reg_wdata;
                A_MONTH: q.month <= reg_wdata;
                A_DOW:   q.dow   <= reg_wdata;
                A_YEAR:  q.year  <= reg_wdata;
                default: ;
            endcase
        end else if (tick) begin
            q <= nxt;
        end
    end

    always_comb begin
        case (addr)
            A_SEC:   reg_rdata = q.sec;
            A_MIN:   reg_rdata = q.min;
            A_HOUR:  reg_rdata = q.hour;
            A_DATE:  reg_rdata = q.date;
            A_MONTH: reg_rdata = q.month;
            A_DOW:   reg_rdata = q.dow;
            A_YEAR:  reg_rdata = q.year;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign snap_out = q;

    // R4: a halted clock holds every register unless the host writes
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (q.sec[7] && !reg_we) |=> $stable(q));

    // R5: seconds wrap from 59 to 00 on a tick
    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !reg_we && q.sec[6:0] == 7'h59) |=> (q.sec[6:0] == 7'h00));

    // R7: 11:59:59 in 12-hour form becomes 12 with the PM flag flipped
    p_pm_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !reg_we && q.hour[7] && q.hour[4:0] == 5'h11 &&
         q.min == 8'h59 && q.sec[6:0] == 7'h59)
        |=> (q.hour[4:0] == 5'h12 && q.hour[5] != $past(q.hour[5])));

    // R12: a write to minutes lands unchanged, whatever the tick did
    p_write_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd1) |=> (q.min == $past(reg_wdata)));

endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbase_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [55:0] snap_out;

    bcd_rtc_core #(.DIV_RATIO(DIV)) uut (
        .clk(clk), .rst(rst), .tbase_en(tbase_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .snap_out(snap_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // Behavioural reference state, held as plain integers
    int m_sec, m_min, m_hr, m_m12, m_pm, m_halt, m_date, m_mon, m_dow, m_yr, m_cnt;
    int m_raw7;  // stray bit 6 of hours is never written by this bench

    function automatic int enc(int v); return (v / 10) * 16 + (v % 10); endfunction
    function automatic int dec(logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction

    function automatic logic [55:0] model_snap();
        logic [7:0] h;
        if (m_m12 != 0) h = 8'h80 | (m_pm != 0 ? 8'h20 : 8'h00) | 8'(enc(m_hr));
        else            h = 8'(enc(m_hr));
        return {8'(enc(m_yr)), 8'(m_dow), 8'(enc(m_mon)), 8'(enc(m_date)), h,
                8'(enc(m_min)), (m_halt != 0 ? 8'h80 : 8'h00) | 8'(enc(m_sec))};
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_m12 = 0; m_pm = 0; m_halt = 0;
        m_date = 1; m_mon = 1; m_dow = 1; m_yr = 0; m_cnt = 0; m_raw7 = 0;
    endtask

    task automatic model_write(int a, logic [7:0] d);
        case (a)
            0: begin m_halt = d[7]; m_sec = dec({1'b0, d[6:0]}); m_cnt = 0; end
            1: m_min = dec(d);
            2: begin
                m_m12 = d[7];
                if (d[7]) begin m_pm = d[5]; m_hr = dec({3'b0, d[4:0]}); end
                else begin m_pm = 0; m_hr = dec({2'b0, d[5:0]}); end
            end
            3: m_date = dec(d);
            4: m_mon = dec(d);
            5: m_dow = d;
            6: m_yr = dec(d);
            default: ;
        endcase
    endtask

    task automatic model_second();
        bit nd = 0;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0;
        if (m_m12 != 0) begin
            if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; nd = (m_pm == 0); end
            else if (m_hr == 12) m_hr = 1;
            else m_hr++;
        end else begin
            m_hr++;
            if (m_hr == 24) begin m_hr = 0; nd = 1; end
        end
        if (!nd) return;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        if (m_date < days_in(m_mon, m_yr)) begin m_date++; return; end
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_yr = (m_yr + 1) % 100;
    endtask

    task automatic chk(string t, logic [55:0] act, logic [55:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // Drive one cycle: inputs set at a falling edge, compared at the next one.
    task automatic cyc(bit r, bit e, bit w, int a, logic [7:0] d);
        bit halted;
        rst = r; tbase_en = e; reg_we = w; reg_addr = 3'(a); reg_wdata = d;
        halted = (m_halt != 0);
        if (r) model_reset();
        else begin
            if (e && !halted) begin
                if (m_cnt == DIV - 1) begin
                    m_cnt = 0;
                    if (!w) model_second();
                end else m_cnt++;
            end
            if (w) model_write(a, d);
        end
        @(negedge clk);
        chk(tag, snap_out, model_snap());
    endtask

    task automatic run(int n, bit e = 1);
        for (int i = 0; i < n; i++) cyc(0, e, 0, 0, 8'h00);
    endtask

    task automatic wr(int a, logic [7:0] d); cyc(0, 1, 1, a, d); endtask

    task automatic set_all(logic [7:0] yr, logic [7:0] dw, logic [7:0] mo, logic [7:0] dt,
                           logic [7:0] hr, logic [7:0] mi, logic [7:0] se);
        wr(6, yr); wr(5, dw); wr(4, mo); wr(3, dt); wr(2, hr); wr(1, mi); wr(0, se);
    endtask

    task automatic rd(string t, int a, logic [7:0] exp);
        reg_addr = 3'(a); reg_we = 1'b0; tbase_en = 1'b0;
        #1;
        tests++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: read addr %0d actual %h expected %h", t, a, reg_rdata, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 8'h00);
        chk("R1 reset state", snap_out, 56'h00_01_01_01_00_00_00);

        // R2: write every register, read back, check snapshot layout and address 7
        tag = "R2";
        set_all(8'h42, 8'h03, 8'h07, 8'h19, 8'h14, 8'h25, 8'h33);
        rd("R2", 0, 8'h33); rd("R2", 1, 8'h25); rd("R2", 2, 8'h14); rd("R2", 3, 8'h19);
        rd("R2", 4, 8'h07); rd("R2", 5, 8'h03); rd("R2", 6, 8'h42); rd("R2", 7, 8'h00);
        wr(7, 8'hFF);
        chk("R2 address 7 write ignored", snap_out, 56'h42_03_07_19_14_25_33);

        // R3: one tick per DIV enables, gated enable does not count
        tag = "R3";
        wr(0, 8'h10);
        run(3);
        chk("R3 no tick before ratio", {48'h0, snap_out[7:0]}, {48'h0, 8'h10});
        run(5, 0);
        run(1);
        chk("R3 tick after ratio", {48'h0, snap_out[7:0]}, {48'h0, 8'h11});

        // R12: a write on the tick cycle wins and the tick is lost
        tag = "R12";
        wr(0, 8'h10);
        run(3);
        wr(1, 8'h30);
        chk("R12 write beats tick", {40'h0, snap_out[15:0]}, {40'h0, 16'h30_10});
        run(4);
        chk("R12 next tick counts", {48'h0, snap_out[7:0]}, {48'h0, 8'h11});

        // R5 R6 R8 R10: 24-hour midnight at the end of April, Sunday wrap
        tag = "R6";
        set_all(8'h23, 8'h07, 8'h04, 8'h30, 8'h23, 8'h59, 8'h58);
        run(8);
        chk("R5 R6 R8 R10 midnight", snap_out, 56'h23_01_05_01_00_00_00);

        // R8: 31-day January and 30-day November
        tag = "R8";
        set_all(8'h10, 8'h02, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59);
        run(4);
        chk("R8 Jan 31", snap_out, 56'h10_03_02_01_00_00_00);
        set_all(8'h10, 8'h02, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59);
        run(4);
        chk("R8 Nov 30", snap_out, 56'h10_03_12_01_00_00_00);

        // R7: noon, 1 PM, and 11 PM to midnight
        tag = "R7";
        set_all(8'h15, 8'h03, 8'h06, 8'h15, 8'h91, 8'h59, 8'h58);
        run(8);
        chk("R7 11 AM to 12 PM", snap_out, 56'h15_03_06_15_B2_00_00);
        set_all(8'h15, 8'h03, 8'h06, 8'h15, 8'hB2, 8'h59, 8'h59);
        run(4);
        chk("R7 12 PM to 1 PM", snap_out, 56'h15_03_06_15_A1_00_00);

        // R7 R11: 11 PM on December 31 of year 99
        tag = "R11";
        set_all(8'h99, 8'h05, 8'h12, 8'h31, 8'hB1, 8'h59, 8'h58);
        run(8);
        chk("R7 R11 year wrap", snap_out, 56'h00_06_01_01_92_00_00);

        // R9: February in years 23, 24 and 00
        tag = "R9";
        set_all(8'h23, 8'h01, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        run(4);
        chk("R9 non-leap Feb 28", snap_out, 56'h23_02_03_01_00_00_00);
        set_all(8'h24, 8'h01, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        run(4);
        chk("R9 leap Feb 28", snap_out, 56'h24_02_02_29_00_00_00);
        wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
        run(4);
        chk("R9 leap Feb 29", snap_out, 56'h24_03_03_01_00_00_00);
        set_all(8'h00, 8'h07, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        run(4);
        chk("R9 R10 year 00 leap", snap_out, 56'h00_01_02_29_00_00_00);

        // R4: halt freezes everything, clearing it resumes
        tag = "R4";
        wr(0, 8'h85);
        run(12);
        chk("R4 halted", {48'h0, snap_out[7:0]}, {48'h0, 8'h85});
        wr(0, 8'h05);
        run(4);
        chk("R4 resumed", {48'h0, snap_out[7:0]}, {48'h0, 8'h06});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule